// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter for an 8-bit Processor

This block gathers the interrupt request lines of a small 8-bit processor and decides which one is serviced. There are five lines: a non-maskable trap, three restart lines at levels 7.5, 6.5 and 5.5, and one general request. Each restart line has its own mask bit, and a global enable gates every line except the trap. The processor pulses a sample strobe in the next-to-last clock cycle of each instruction. The arbiter looks at its lines only at that strobe.

When a line wins, the arbiter raises a one-cycle accept pulse. For the trap and restart lines it also drives the 16-bit vector of a restart that the processor inserts itself, with no bus acknowledge cycle. When the general request wins, the arbiter instead raises an acknowledge strobe. The processor holds its program counter and uses this strobe in place of its read strobe, so that an external device can place an instruction on the bus. The current mask and the raw pending state of every line are available at all times.

Top module: `irq_arbiter`

## Requirements
- R1: Reset clears the global enable, sets all three mask bits (mask_o = 3'b111), clears the latched 7.5 request and drives accept_o, ack_o and vector_o to zero.
- R2: Priority from highest to lowest is trap, 7.5, 6.5, 5.5, general request. Every restart line outranks the general request.
- R3: The trap is accepted whenever it is high at a strobe, whatever the mask bits and the global enable are. Accepting it leaves the global enable unchanged.
- R4: Lines are evaluated only in a cycle where sample_i is high. The result (accept_o, vector_o, ack_o) appears in the following cycle, and accept_o is a single-cycle pulse.
- R5: vector_o carries 16'h0024 for the trap, 16'h003C for 7.5, 16'h0034 for 6.5 and 16'h002C for 5.5 during the accept pulse. At all other times it is zero.
- R6: Accepting the general request raises ack_o together with accept_o, with vector_o = 0. Accepting the trap or a restart line never raises ack_o.
- R7: en_set_i sets the global enable and en_clr_i clears it. Accepting any maskable line clears the enable, and this clearing wins over en_set_i in the same cycle. While the enable is low, only the trap can be accepted.
- R8: mask_wr_i loads mask_data_i into the mask, with bit 2 for 7.5, bit 1 for 6.5 and bit 0 for 5.5. A masked line takes no part in arbitration but still shows in pending_o.
- R9: A rising edge on the 7.5 line latches a request. The request stays pending after the line falls, until the 7.5 line is accepted or a mask write with clr75_i high clears it.
- R10: At most one line is accepted per strobe. A lower-priority line that loses stays pending and can win at a later strobe.
- R11: The 6.5, 5.5, trap and general lines are level-sensitive. pending_o = {trap, latched 7.5, 6.5, 5.5, general}, from bit 4 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Instruction-boundary sample strobe |
| trap_i | input | 1 | Non-maskable trap request |
| rst75_i | input | 1 | Edge-latched restart request, level 7.5 |
| rst65_i | input | 1 | Level restart request, level 6.5 |
| rst55_i | input | 1 | Level restart request, level 5.5 |
| gen_i | input | 1 | General request, answered externally |
| en_set_i | input | 1 | Set the global enable |
| en_clr_i | input | 1 | Clear the global enable |
| mask_wr_i | input | 1 | Load the mask bits |
| mask_data_i | input | 3 | New mask value {7.5, 6.5, 5.5} |
| clr75_i | input | 1 | With mask_wr_i, clear the latched 7.5 request |
| accept_o | output | 1 | One-cycle pulse: a line was accepted |
| vector_o | output | 16 | Restart vector during the accept pulse |
| ack_o | output | 1 | Acknowledge strobe for the general request |
| ien_o | output | 1 | Global enable state |
| mask_o | output | 3 | Mask state {7.5, 6.5, 5.5} |
| pending_o | output | 5 | Raw pending lines {trap, 7.5, 6.5, 5.5, general} |

## Verification
Each accept result (accept_o, vector_o, ack_o and the enable clearing) is registered, so it becomes visible exactly one clock after the edge that sees sample_i high. The bench raises the strobe at a falling edge and reads the results at the next falling edge. A 7.5 edge needs one clock to latch before it shows in pending_o, so the bench waits one full cycle after changing the lines before it reads pending_o or strobes. Mask and enable writes also take effect one clock later, and they are settled before any strobe.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter logic [15:0] VEC_TRAP = 16'h0024,
  parameter logic [15:0] VEC_R75  = 16'h003C,
  parameter logic [15:0] VEC_R65  = 16'h0034,
  parameter logic [15:0] VEC_R55  = 16'h002C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_i,
  input  logic        trap_i,
  input  logic        rst75_i,
  input  logic        rst65_i,
  input  logic        rst55_i,
  input  logic        gen_i,
  input  logic        en_set_i,
  input  logic        en_clr_i,
  input  logic        mask_wr_i,
  input  logic [2:0]  mask_data_i,
  input  logic        clr75_i,
  output logic        accept_o,
  output logic [15:0] vector_o,
  output logic        ack_o,
  output logic        ien_o,
  output logic [2:0]  mask_o,
  output logic [4:0]  pending_o
);

  logic       ien_q, l75_q, prev75_q;
  logic [2:0] mask_q;
  logic [4:0] elig, grant;
  logic [15:0] vec_sel;

  wire rise75 = rst75_i & ~prev75_q;

  assign elig[4] = trap_i;
  assign elig[3] = ien_q & ~mask_q[2] & l75_q;
  assign elig[2] = ien_q & ~mask_q[1] & rst65_i;
  assign elig[1] = ien_q & ~mask_q[0] & rst55_i;
  assign elig[0] = ien_q & gen_i;

  assign grant[4] = elig[4];
  assign grant[3] = elig[3] & ~elig[4];
  assign grant[2] = elig[2] & ~|elig[4:3];
  assign grant[1] = elig[1] & ~|elig[4:2];
  assign grant[0] = elig[0] & ~|elig[4:1];

  wire take      = sample_i & |elig;
  wire take_mask = sample_i & |grant[3:0];

  always_comb begin
    unique case (1'b1)
      grant[4]: vec_sel = VEC_TRAP;
      grant[3]: vec_sel = VEC_R75;
      grant[2]: vec_sel = VEC_R65;
      grant[1]: vec_sel = VEC_R55;
      default:  vec_sel = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_o <= 1'b0;
      ack_o    <= 1'b0;
      vector_o <= 16'h0000;
      ien_q    <= 1'b0;
      mask_q   <= 3'b111;
      l75_q    <= 1'b0;
      prev75_q <= 1'b0;
    end else begin
      accept_o <= take;
      ack_o    <= sample_i & grant[0];
      vector_o <= take ? vec_sel : 16'h0000;
      prev75_q <= rst75_i;

      if (take_mask)     ien_q <= 1'b0;
      else if (en_clr_i) ien_q <= 1'b0;
      else if (en_set_i) ien_q <= 1'b1;

      if (mask_wr_i) mask_q <= mask_data_i;

      if (rise75)
        l75_q <= 1'b1;
      else if ((sample_i & grant[3]) | (mask_wr_i & clr75_i))
        l75_q <= 1'b0;
    end
  end

  assign ien_o     = ien_q;
  assign mask_o    = mask_q;
  assign pending_o = {trap_i, l75_q, rst65_i, rst55_i, gen_i};

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sample_i,
  input logic        trap_i,
  input logic        accept_o,
  input logic [15:0] vector_o,
  input logic        ack_o,
  input logic        ien_o,
  input logic [2:0]  mask_o
);

  property p_reset_state;
    @(posedge clk) !rst_n |=> (!ien_o && mask_o == 3'b111 && !accept_o && !ack_o);
  endproperty
  assert_reset_state_R1: assert property (p_reset_state);

  assert_trap_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && sample_i && trap_i) |-> (accept_o && vector_o == 16'h0024));

  assert_only_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> $past(sample_i));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !accept_o);

  assert_vector_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_o |-> vector_o == 16'h0000);

  assert_ack_general_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (accept_o && vector_o == 16'h0000));

  assert_enable_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && vector_o != 16'h0024) |-> !ien_o);

endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .trap_i(trap_i),
  .accept_o(accept_o), .vector_o(vector_o), .ack_o(ack_o),
  .ien_o(ien_o), .mask_o(mask_o)
);

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic sample_i = 0, trap_i = 0, rst75_i = 0, rst65_i = 0, rst55_i = 0, gen_i = 0;
  logic en_set_i = 0, en_clr_i = 0, mask_wr_i = 0, clr75_i = 0;
  logic [2:0] mask_data_i = 0;
  logic accept_o, ack_o, ien_o;
  logic [15:0] vector_o;
  logic [2:0] mask_o;
  logic [4:0] pending_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_arbiter dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic lines(logic t, logic a, logic b, logic c, logic g);
    trap_i = t; rst75_i = a; rst65_i = b; rst55_i = c; gen_i = g;
  endtask

  task automatic wr_mask(logic [2:0] m, logic clr);
    mask_wr_i = 1; mask_data_i = m; clr75_i = clr; cyc();
    mask_wr_i = 0; clr75_i = 0;
  endtask

  task automatic enable(); en_set_i = 1; cyc(); en_set_i = 0; endtask
  task automatic disable_ie(); en_clr_i = 1; cyc(); en_clr_i = 0; endtask
  task automatic strobe(); sample_i = 1; cyc(); sample_i = 0; endtask

  function automatic logic [15:0] exp_vec(logic [4:0] v);
    if (v[4]) return 16'h0024;
    if (v[3]) return 16'h003C;
    if (v[2]) return 16'h0034;
    if (v[1]) return 16'h002C;
    return 16'h0000;
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    chk("R1 ien", ien_o, 0);
    chk("R1 mask", mask_o, 3'b111);
    chk("R1 accept", accept_o, 0);
    chk("R1 vector", vector_o, 0);
    rst_n = 1; cyc();
    chk("R1 pending", pending_o, 0);

    // R2 R5 R6 R7 R10: sweep all line combinations, enabled and unmasked
    for (int v = 0; v < 32; v++) begin
      lines(0, 0, 0, 0, 0);
      wr_mask(3'b000, 1);
      enable();
      lines(v[4], v[3], v[2], v[1], v[0]);
      cyc();
      chk("R11 pending", pending_o, v[4:0]);
      chk("R4 no accept without strobe", accept_o, 0);
      strobe();
      chk("R2 accept", accept_o, v != 0);
      chk("R5 vector", vector_o, exp_vec(v[4:0]));
      chk("R6 ack", ack_o, v[4:0] == 5'b00001);
      chk("R7 ien after accept", ien_o, (v[4] || v == 0) ? 1'b1 : 1'b0);
      cyc();
      chk("R4 pulse ends", accept_o, 0);
      chk("R10 loser pending", pending_o[0], v[0]);
    end

    // R8: masks over all values with every maskable line high
    for (int m = 0; m < 8; m++) begin
      lines(0, 0, 0, 0, 0);
      wr_mask(m[2:0], 1);
      enable();
      lines(0, 1, 1, 1, 1);
      cyc();
      chk("R8 mask", mask_o, m[2:0]);
      chk("R8 pending while masked", pending_o, 5'b01111);
      strobe();
      chk("R8 vector", vector_o,
          !m[2] ? 16'h003C : !m[1] ? 16'h0034 : !m[0] ? 16'h002C : 16'h0000);
      chk("R8 ack", ack_o, m == 7);
    end

    // R3 R7: enable low blocks all but trap
    lines(0, 0, 0, 0, 0);
    wr_mask(3'b000, 1);
    disable_ie();
    lines(0, 1, 1, 1, 1); cyc();
    strobe();
    chk("R7 disabled no accept", accept_o, 0);
    trap_i = 1; cyc();
    strobe();
    chk("R3 trap while disabled", vector_o, 16'h0024);
    chk("R3 ien untouched", ien_o, 0);
    lines(0, 0, 0, 0, 0);
    wr_mask(3'b111, 1);
    enable();
    trap_i = 1; cyc();
    strobe();
    chk("R3 trap while masked", vector_o, 16'h0024);
    chk("R3 ien kept", ien_o, 1);
    trap_i = 0;

    // R7: accept clearing beats a simultaneous set
    wr_mask(3'b000, 1);
    gen_i = 1; cyc();
    sample_i = 1; en_set_i = 1; cyc(); sample_i = 0; en_set_i = 0;
    chk("R7 clear wins over set", ien_o, 0);
    chk("R6 general ack", ack_o, 1);
    gen_i = 0;

    // R9: edge latch of 7.5
    enable();
    rst75_i = 1; cyc(); rst75_i = 0; cyc(); cyc();
    chk("R9 latched after fall", pending_o[3], 1);
    wr_mask(3'b000, 0);
    chk("R9 kept without clear", pending_o[3], 1);
    wr_mask(3'b000, 1);
    chk("R9 cleared by write", pending_o[3], 0);
    rst75_i = 1; cyc();
    strobe();
    chk("R9 serviced vector", vector_o, 16'h003C);
    chk("R9 cleared by service", pending_o[3], 0);
    rst75_i = 0;

    // R10: loser reconsidered at later strobe
    enable();
    lines(0, 0, 1, 1, 0); cyc();
    strobe();
    chk("R10 first winner", vector_o, 16'h0034);
    chk("R10 5.5 still pending", pending_o[1], 1);
    rst65_i = 0; enable();
    strobe();
    chk("R10 second winner", vector_o, 16'h002C);

    // R11: level line dropped before strobe is not accepted
    enable();
    rst55_i = 0; cyc();
    strobe();
    chk("R11 dropped level", accept_o, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule